// File: doc/BRIEF.md
# Ten-Candidate Hit Frame Packer

Once per frame this block gathers the candidate objects reported by eight upstream processing units. Each unit owns two candidate slots (a left one and a right one), and each slot carries a presence flag and eight threshold-pass bits. The block packs these into one 96-bit word for a downstream frame serializer. The word opens with a 16-bit occupancy map. After the map come the threshold words of up to ten present candidates, taken in ascending slot order.

Any present candidate after the tenth is dropped from the entry list. It still shows in the map. The frame that carries it raises an overflow flag, and a saturating counter records how many such frames have occurred. The block accepts a new frame on every clock and returns the packed result two clocks later. One slot of the compaction pipeline sits between the capture registers and the output registers.

Top module: `hfp_frame_packer`

## Requirements
- R1: While reset is held, and until the first accepted frame emerges, `frame_valid`, `overflow`, `frame_data` and `overflow_count` are all zero.
- R2: A frame accepted on a clock edge with `frame_strobe` high appears with `frame_valid` high exactly two rising edges later. Strobes on consecutive clocks each yield their own output frame, and `frame_valid` is never high without such a strobe.
- R3: `frame_data[15:0]` equals the presence flags of the accepted frame. Bit i is slot i. Slot 2u is the left slot of unit u and slot 2u+1 is its right slot.
- R4: Entry j sits at `frame_data[16+8j+7:16+8j]` for j = 0..9. It holds the threshold byte of the present slot that has exactly j present slots below it. The threshold byte of slot i is `slot_hits[8i+7:8i]`.
- R5: When fewer than ten slots are present, every entry position beyond the last present candidate is zero.
- R6: When more than ten slots are present, only the ten lowest-numbered present slots fill the entries, and the map still shows every present slot.
- R7: `overflow` is high with a frame exactly when that frame has more than ten present slots.
- R8: `overflow_count` rises by one on each output frame with `overflow` high. It stops at 65535 and never decreases outside reset.
- R9: Threshold bits of slots whose presence flag is low have no effect on `frame_data`. Inputs presented while `frame_strobe` is low have no effect on any output.
- R10: Between output frames, `frame_data` and `overflow` keep the values of the last frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Frame clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_strobe | input | 1 | Accept the slot inputs this cycle |
| slot_valid | input | 16 | Presence flag per candidate slot |
| slot_hits | input | 128 | Threshold-pass byte per slot, slot i at bits 8i+7:8i |
| frame_valid | output | 1 | Packed frame presented this cycle |
| frame_data | output | 96 | Map in 15:0, entries above |
| overflow | output | 1 | Frame had more than ten candidates |
| overflow_count | output | 16 | Saturating count of overflow frames |

## Verification
A wrong slot rank would place a threshold byte in the wrong entry, or leave a zero hole inside the entry list. This shows in the very frame whose presence pattern triggers it, two cycles after the strobe. Every one of the 65536 presence patterns is pushed through back to back, so every rank combination reaches the ports. A broken overflow comparison or counter step shows at once in the flag, and also in the running count, which the bench tracks every cycle and pushes into saturation. An enable error in the pipeline shows as a frame that changes during an idle cycle.

// File: rtl/hfp_pkg.sv
package hfp_pkg;
  localparam int DEF_UNITS   = 8;
  localparam int DEF_SIDES   = 2;
  localparam int DEF_HIT_W   = 8;
  localparam int DEF_ENTRIES = 10;
  localparam int DEF_CNT_W   = 16;

  function automatic int frame_width(input int units, input int sides,
                                     input int entries, input int hit_w);
    return units * sides + entries * hit_w;
  endfunction
endpackage

// File: rtl/hfp_capture.sv
module hfp_capture #(
  parameter int SLOTS = 16,
  parameter int HIT_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   strobe_i,
  input  logic [SLOTS-1:0]       valid_i,
  input  logic [SLOTS*HIT_W-1:0] hits_i,
  output logic                   s1_valid_o,
  output logic [SLOTS-1:0]       s1_map_o,
  output logic [SLOTS*HIT_W-1:0] s1_hits_o
);
  logic [SLOTS*HIT_W-1:0] hits_masked;

  // zero the bytes of absent slots so they never reach the compactor
  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      hits_masked[i*HIT_W +: HIT_W] = valid_i[i] ? hits_i[i*HIT_W +: HIT_W] : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid_o <= 1'b0;
      s1_map_o   <= '0;
      s1_hits_o  <= '0;
    end else begin
      s1_valid_o <= strobe_i;
      if (strobe_i) begin
        s1_map_o  <= valid_i;
        s1_hits_o <= hits_masked;
      end
    end
  end
endmodule

// File: rtl/hfp_rank.sv
module hfp_rank #(
  parameter int SLOTS  = 16,
  parameter int RANK_W = 5
) (
  input  logic [SLOTS-1:0]        map_i,
  output logic [SLOTS*RANK_W-1:0] rank_o,
  output logic [RANK_W-1:0]       total_o
);
  for (genvar i = 0; i < SLOTS; i++) begin : g_rank
    logic [RANK_W-1:0] acc;
    always_comb begin
      acc = '0;
      for (int j = 0; j < i; j++) begin
        acc = acc + RANK_W'(map_i[j]);
      end
    end
    assign rank_o[i*RANK_W +: RANK_W] = acc;
  end

  always_comb begin
    total_o = '0;
    for (int k = 0; k < SLOTS; k++) begin
      total_o = total_o + RANK_W'(map_i[k]);
    end
  end
endmodule

// File: rtl/hfp_compact.sv
module hfp_compact #(
  parameter int SLOTS   = 16,
  parameter int HIT_W   = 8,
  parameter int ENTRIES = 10,
  parameter int RANK_W  = 5
) (
  input  logic [SLOTS-1:0]         map_i,
  input  logic [SLOTS*HIT_W-1:0]   hits_i,
  input  logic [SLOTS*RANK_W-1:0]  rank_i,
  output logic [ENTRIES*HIT_W-1:0] entries_o
);
  for (genvar j = 0; j < ENTRIES; j++) begin : g_entry
    logic [HIT_W-1:0] pick;
    always_comb begin
      pick = '0;
      for (int i = 0; i < SLOTS; i++) begin
        if (map_i[i] && (rank_i[i*RANK_W +: RANK_W] == RANK_W'(j))) begin
          pick = pick | hits_i[i*HIT_W +: HIT_W];
        end
      end
    end
    assign entries_o[j*HIT_W +: HIT_W] = pick;
  end
endmodule

// File: rtl/hfp_sat_counter.sv
module hfp_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  output logic [W-1:0] count_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (inc_i && (cnt_q != '1)) begin
      cnt_d = cnt_q + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (inc_i) begin
      cnt_q <= cnt_d;
    end
  end

  assign count_o = cnt_q;

  // R8: the count only moves upward by one
  a_r8_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + W'(1)));

  // R8: once full, the count stays full
  a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt_q) == '1) |-> (cnt_q == '1));
endmodule

// File: rtl/hfp_frame_packer.sv
module hfp_frame_packer
  import hfp_pkg::*;
#(
  parameter int UNITS   = DEF_UNITS,
  parameter int SIDES   = DEF_SIDES,
  parameter int HIT_W   = DEF_HIT_W,
  parameter int ENTRIES = DEF_ENTRIES,
  parameter int CNT_W   = DEF_CNT_W
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   frame_strobe,
  input  logic [UNITS*SIDES-1:0]                 slot_valid,
  input  logic [UNITS*SIDES*HIT_W-1:0]           slot_hits,
  output logic                                   frame_valid,
  output logic [UNITS*SIDES+ENTRIES*HIT_W-1:0]   frame_data,
  output logic                                   overflow,
  output logic [CNT_W-1:0]                       overflow_count
);
  localparam int SLOTS   = UNITS * SIDES;
  localparam int MAP_W   = SLOTS;
  localparam int RANK_W  = $clog2(SLOTS + 1);
  localparam int ENTRY_W = ENTRIES * HIT_W;
  localparam int FRAME_W = frame_width(UNITS, SIDES, ENTRIES, HIT_W);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  // stage 1: capture
  logic                   s1_valid;
  logic [SLOTS-1:0]       s1_map;
  logic [SLOTS*HIT_W-1:0] s1_hits;

  hfp_capture #(.SLOTS(SLOTS), .HIT_W(HIT_W)) u_capture (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .strobe_i   (frame_strobe),
    .valid_i    (slot_valid),
    .hits_i     (slot_hits),
    .s1_valid_o (s1_valid),
    .s1_map_o   (s1_map),
    .s1_hits_o  (s1_hits)
  );

  // stage 2: rank and compact
  logic [SLOTS*RANK_W-1:0] ranks;
  logic [RANK_W-1:0]       total;
  logic [ENTRY_W-1:0]      entries;

  hfp_rank #(.SLOTS(SLOTS), .RANK_W(RANK_W)) u_rank (
    .map_i   (s1_map),
    .rank_o  (ranks),
    .total_o (total)
  );

  hfp_compact #(.SLOTS(SLOTS), .HIT_W(HIT_W), .ENTRIES(ENTRIES), .RANK_W(RANK_W)) u_compact (
    .map_i     (s1_map),
    .hits_i    (s1_hits),
    .rank_i    (ranks),
    .entries_o (entries)
  );

  // output registers
  logic [FRAME_W-1:0] frame_d;
  logic               ovf_d;
  logic [FRAME_W-1:0] frame_q;
  logic               ovf_q;
  logic               fv_q;

  always_comb begin
    frame_d = {entries, s1_map};
    ovf_d   = (total > RANK_W'(ENTRIES));
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      fv_q    <= 1'b0;
      frame_q <= '0;
      ovf_q   <= 1'b0;
    end else begin
      fv_q <= s1_valid;
      if (s1_valid) begin
        frame_q <= frame_d;
        ovf_q   <= ovf_d;
      end
    end
  end

  hfp_sat_counter #(.W(CNT_W)) u_ovf_cnt (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .inc_i   (s1_valid & ovf_d),
    .count_o (overflow_count)
  );

  assign frame_valid = fv_q;
  assign frame_data  = frame_q;
  assign overflow    = ovf_q;

  // R2: a captured frame is presented on the next edge
  a_r2_capture_to_out: assert property (@(posedge clk) disable iff (!rst_int_n)
    s1_valid |=> frame_valid);

  // R2: no output frame without a capture one edge earlier
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_int_n)
    frame_valid |-> $past(s1_valid));

  // R7: flag agrees with the population of the emitted map
  a_r7_flag_matches_map: assert property (@(posedge clk) disable iff (!rst_int_n)
    frame_valid |-> (overflow == ($countones(frame_data[MAP_W-1:0]) > ENTRIES)));

  // R5: an empty map carries no entries
  a_r5_empty_frame: assert property (@(posedge clk) disable iff (!rst_int_n)
    (frame_valid && (frame_data[MAP_W-1:0] == '0)) |-> (frame_data[FRAME_W-1:MAP_W] == '0));

  // R10: outputs hold between frames
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_int_n)
    !frame_valid |-> ($stable(frame_data) && $stable(overflow)));
endmodule

// File: tb/tb_hfp_frame_packer.sv
module tb_hfp_frame_packer;
  localparam int CLK_PERIOD = 10;
  localparam int SLOTS = 16;
  localparam int HIT_W = 8;
  localparam int ENT   = 10;
  localparam int FW    = SLOTS + ENT * HIT_W;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic                   frame_strobe = 1'b0;
  logic [SLOTS-1:0]       slot_valid = '0;
  logic [SLOTS*HIT_W-1:0] slot_hits = '0;
  logic                   frame_valid;
  logic [FW-1:0]          frame_data;
  logic                   overflow;
  logic [15:0]            overflow_count;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hfp_frame_packer dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .frame_strobe   (frame_strobe),
    .slot_valid     (slot_valid),
    .slot_hits      (slot_hits),
    .frame_valid    (frame_valid),
    .frame_data     (frame_data),
    .overflow       (overflow),
    .overflow_count (overflow_count)
  );

  // expected-value pipeline, two stages deep
  bit          e0_v = 0, e1_v = 0;
  logic [FW:0] e0 = '0, e1 = '0;
  logic [FW-1:0] last_data = '0;
  logic          last_ovf = 1'b0;
  int            exp_cnt = 0;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [FW:0] pack(input logic [SLOTS-1:0] m, input logic [SLOTS*HIT_W-1:0] h);
    logic [FW-1:0] d;
    int k;
    d = '0;
    d[SLOTS-1:0] = m;
    k = 0;
    for (int i = 0; i < SLOTS; i++) begin
      if (m[i]) begin
        if (k < ENT) d[SLOTS + 8*k +: 8] = h[8*i +: 8];
        k++;
      end
    end
    return {(k > ENT), d};
  endfunction

  // called at a falling edge: check output for frame driven two falls ago, then drive
  task automatic step(input bit sv, input logic [SLOTS-1:0] m, input logic [SLOTS*HIT_W-1:0] h);
    @(negedge clk);
    if (e1_v) begin
      if (e1[FW] && exp_cnt < 65535) exp_cnt++;
      chk(frame_valid == 1'b1, "R2 frame_valid", 128'(frame_valid), 128'(1));
      chk(frame_data[SLOTS-1:0] == e1[SLOTS-1:0], "R3 map", 128'(frame_data[SLOTS-1:0]), 128'(e1[SLOTS-1:0]));
      chk(frame_data[FW-1:SLOTS] == e1[FW-1:SLOTS], "R4 R5 R6 R9 entries",
          128'(frame_data[FW-1:SLOTS]), 128'(e1[FW-1:SLOTS]));
      chk(overflow == e1[FW], "R7 overflow", 128'(overflow), 128'(e1[FW]));
      last_data = e1[FW-1:0];
      last_ovf  = e1[FW];
    end else begin
      chk(frame_valid == 1'b0, "R2 idle frame_valid", 128'(frame_valid), 128'(0));
      chk(frame_data == last_data && overflow == last_ovf, "R10 R9 hold",
          128'(frame_data), 128'(last_data));
    end
    chk(overflow_count == 16'(exp_cnt), "R8 count", 128'(overflow_count), 128'(exp_cnt));
    e1_v = e0_v; e1 = e0;
    e0_v = sv;   e0 = pack(m, h);
    frame_strobe = sv;
    slot_valid   = m;
    slot_hits    = h;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [SLOTS*HIT_W-1:0] h;
    int cyc;
    // R1: held in reset
    repeat (3) @(negedge clk);
    chk(frame_valid == 0 && overflow == 0 && frame_data == '0 && overflow_count == 0,
        "R1 in reset", 128'(frame_data), 128'(0));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(frame_valid == 0 && overflow == 0 && frame_data == '0 && overflow_count == 0,
        "R1 after release", 128'(frame_data), 128'(0));

    // sweep every presence pattern, with idle cycles carrying junk
    cyc = 0;
    for (int p = 0; p < 65536; ) begin
      if (cyc % 5 == 4) begin
        step(1'b0, 16'(p * 3 + 1), {SLOTS*HIT_W{1'b1}});
      end else begin
        for (int i = 0; i < SLOTS; i++) begin
          if (p[i]) h[8*i +: 8] = 8'(p * 7 + i * 29 + (p >> 8) + 1);
          else      h[8*i +: 8] = 8'hA5 ^ 8'(i);   // R9: junk in absent slots
        end
        step(1'b1, 16'(p), h);
        p++;
      end
      cyc++;
    end

    // R8: drive the overflow count into saturation
    for (int n = 0; n < 58660; n++) begin
      for (int i = 0; i < SLOTS; i++) h[8*i +: 8] = 8'(n + i);
      step(1'b1, 16'hFFFF, h);
    end
    step(1'b0, '0, '0);
    step(1'b0, '0, '0);
    step(1'b0, '0, '0);
    chk(overflow_count == 16'hFFFF, "R8 saturated", 128'(overflow_count), 128'(16'hFFFF));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule